// File: doc/BRIEF.md
# Triggered Power-Trace Averager

This block sits behind an 8-bit sampler that watches the supply current of a processor under observation. The code running on that processor raises a GPIO line just before the region of interest and drops it just after, so each high period of the line marks one capture. The block runs the same code region several times and adds every capture, sample by sample, into an accumulator memory. When the set is complete it divides each sum by the repeat count. It then subtracts a stored reference segment taken while the processor executed only idle instructions.

The normalised trace leaves the block as a stream of fixed-length segments, one for each instruction the known program is expected to execute, in program order. Each beat carries a segment index counted from zero and markers for the first and last beat of the segment. The reference segment is written beforehand through a simple write port and is reused for every instruction slot.

The output uses valid/ready. Once `out_valid` is high it stays high, and data, index and markers stay fixed, until a beat is taken with `out_ready` high. The block never drops or reorders beats under back-pressure. While a trace is being emitted the trigger line is ignored, so the monitored code must not start a new capture until emission ends.

Top module: `trace_avg`

## Requirements
- R1: After reset, `out_valid` and `err_len` are low and no set is in progress.
- R2: A capture starts only on a low-to-high change of `trig` seen after reset. A line that is already high when reset releases starts nothing. Only samples with `smp_valid` high while `trig` is high are taken, and the cycle in which `trig` is seen low ends the capture.
- R3: Each output value before normalisation is floor(sum of the repeats / repeat count). This holds for repeat counts that are powers of two and for those that are not, up to full-scale samples of 255 at 16 repeats.
- R4: `out_data` is the 9-bit two's-complement value average minus reference[p], where p is the beat's position within its segment. The same reference word is used at position p of every segment.
- R5: Beats leave in sample order, in contiguous segments of the latched segment length. `out_idx` starts at 0 and rises by one per segment. `out_first` is high on position 0 and `out_last` on the final position of each segment.
- R6: Only whole segments are emitted; trailing samples that do not fill a segment are dropped. A set shorter than one segment produces no output, and the block returns to waiting for the next capture.
- R7: When a capture in a set has a different number of samples from the first capture of that set, `err_len` pulses high for one cycle after the capture ends. The whole set is discarded, and the next capture begins a new set.
- R8: While `out_valid` is high and `out_ready` is low, all output fields hold. Trigger activity during emission neither starts a capture nor changes the accumulated trace.
- R9: The repeat count (1 to 16, with 0 treated as 1) and the segment length (1 to 128, with 0 treated as 1) are latched at the first capture of a set. Later changes to them take effect only with the next set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A new sample is present this cycle |
| smp_data | input | 8 | Unsigned sample value |
| trig | input | 1 | Capture window line raised and dropped by the monitored code |
| cfg_reps | input | 5 | Number of captures averaged per set |
| cfg_seg_len | input | 8 | Samples per instruction segment |
| ref_we | input | 1 | Write strobe for the reference segment |
| ref_addr | input | 7 | Reference word position |
| ref_data | input | 8 | Reference word value |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 9 | Normalised signed sample |
| out_first | output | 1 | Beat is position 0 of its segment |
| out_last | output | 1 | Beat is the final position of its segment |
| out_idx | output | 10 | Segment (instruction) index from 0 |
| err_len | output | 1 | One-cycle pulse when a set is dropped for a length mismatch |

## Verification
The averaging path is exercised with slowly changing ramps, full-scale samples at the maximum repeat count, and hashed values. Repeat counts of 1, 2, 4 and 16 take the shift path, while 3, 5 and 7 take the reciprocal path, so a rounding error in either path shows up as a single-unit difference. Segment lengths of 1, 4, 8, 16 and 128 are used, along with lengths that leave a tail, so that faults in the index, the markers and the handling of partial segments are caught. Short sets, mismatched sets, configuration changes in the middle of a set, and trigger pulses during a stalled emission each check that state is discarded or kept as required.

// File: rtl/tavg_pkg.sv
package tavg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAP  = 2'd1,
    ST_EMIT = 2'd2
  } tavg_state_e;
endpackage

// File: rtl/tavg_ctrl.sv
module tavg_ctrl
  import tavg_pkg::*;
#(
  parameter int MAX_SAMPLES = 1024,
  parameter int REP_W  = 5,
  parameter int SEGL_W = 8,
  parameter int CNT_W  = 11,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              trig,
  input  logic [REP_W-1:0]  cfg_reps,
  input  logic [SEGL_W-1:0] cfg_seg_len,
  input  logic              emit_done,
  output logic              acc_we,
  output logic              acc_clear,
  output logic [AW-1:0]     acc_addr,
  output logic              emit_active,
  output logic [CNT_W-1:0]  len_q,
  output logic [REP_W-1:0]  reps_q,
  output logic [SEGL_W-1:0] segl_q,
  output logic              err_len
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(MAX_SAMPLES);

  tavg_state_e       st;
  logic              trig_q;
  logic [CNT_W-1:0]  cnt;
  logic [REP_W-1:0]  rep;
  logic              rise, take, last_rep;
  logic [CNT_W-1:0]  fin_len;

  assign rise = trig && !trig_q;

  always_comb begin
    take = 1'b0;
    if (smp_valid) begin
      if (st == ST_IDLE)     take = rise;
      else if (st == ST_CAP) take = trig && (cnt < CNT_LIM);
    end
  end

  assign acc_we      = take;
  assign acc_clear   = (rep == '0);
  assign acc_addr    = (st == ST_IDLE) ? '0 : cnt[AW-1:0];
  assign emit_active = (st == ST_EMIT);
  assign fin_len     = (rep == '0) ? cnt : len_q;
  assign last_rep    = (rep == '0) ? (reps_q == REP_W'(1)) : ((rep + 1'b1) == reps_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      trig_q  <= 1'b1;
      cnt     <= '0;
      rep     <= '0;
      len_q   <= '0;
      reps_q  <= REP_W'(1);
      segl_q  <= SEGL_W'(1);
      err_len <= 1'b0;
    end else begin
      trig_q  <= trig;
      err_len <= 1'b0;
      case (st)
        ST_IDLE: if (rise) begin
          st  <= ST_CAP;
          cnt <= take ? CNT_W'(1) : '0;
          if (rep == '0) begin
            reps_q <= (cfg_reps == '0) ? REP_W'(1) : cfg_reps;
            segl_q <= (cfg_seg_len == '0) ? SEGL_W'(1) : cfg_seg_len;
          end
        end
        ST_CAP: begin
          if (trig) begin
            if (take) cnt <= cnt + 1'b1;
          end else begin
            if (rep == '0) len_q <= cnt;
            if (rep != '0 && cnt != len_q) begin
              err_len <= 1'b1;
              rep     <= '0;
              st      <= ST_IDLE;
            end else if (last_rep) begin
              rep <= '0;
              st  <= (fin_len >= CNT_W'(segl_q)) ? ST_EMIT : ST_IDLE;
            end else begin
              rep <= rep + 1'b1;
              st  <= ST_IDLE;
            end
          end
        end
        ST_EMIT: if (emit_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |=> !err_len);

  // R7
  err_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |-> !$past(trig));

  // R2
  start_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_CAP) |-> $past(trig));
endmodule

// File: rtl/tavg_accmem.sv
module tavg_accmem #(
  parameter int DEPTH = 1024,
  parameter int SMP_W = 8,
  parameter int ACC_W = 12,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic             clear,
  input  logic [AW-1:0]    waddr,
  input  logic [SMP_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [ACC_W-1:0] rdata
);
  logic [ACC_W-1:0] mem [DEPTH];
  logic [ACC_W-1:0] base;

  assign base  = clear ? '0 : mem[waddr];
  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= base + ACC_W'(wdata);
  end
endmodule

// File: rtl/tavg_emit.sv
module tavg_emit #(
  parameter int SMP_W    = 8,
  parameter int ACC_W    = 12,
  parameter int MAX_REPS = 16,
  parameter int MAX_SEG  = 128,
  parameter int REP_W    = 5,
  parameter int SEGA_W   = 7,
  parameter int SEGL_W   = 8,
  parameter int CNT_W    = 11,
  parameter int AW       = 10,
  parameter int IDX_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [CNT_W-1:0]  len_q,
  input  logic [REP_W-1:0]  reps_q,
  input  logic [SEGL_W-1:0] segl_q,
  input  logic [ACC_W-1:0]  acc_rd,
  output logic [AW-1:0]     acc_raddr,
  input  logic              ref_we,
  input  logic [SEGA_W-1:0] ref_addr,
  input  logic [SMP_W-1:0]  ref_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SMP_W:0]    out_data,
  output logic              out_first,
  output logic              out_last,
  output logic [IDX_W-1:0]  out_idx,
  output logic              done
);
  localparam int SH = ACC_W + REP_W;
  localparam int PW = ACC_W + SH + 1;

  logic [SMP_W-1:0]  ref_mem [MAX_SEG];
  logic [CNT_W-1:0]  ptr;
  logic [SEGL_W-1:0] pos;
  logic [IDX_W-1:0]  seg;
  logic              seg_end, no_room;
  logic [SH:0]       recip;
  int                shamt;
  logic [PW-1:0]     prod;
  logic [SMP_W-1:0]  avg, ref_q;

  always_ff @(posedge clk) begin
    if (ref_we) ref_mem[ref_addr] <= ref_data;
  end

  assign ref_q     = ref_mem[pos[SEGA_W-1:0]];
  assign acc_raddr = ptr[AW-1:0];
  assign seg_end   = (pos == segl_q - 1'b1);
  assign no_room   = ({1'b0, ptr} + (CNT_W+1)'(1) + (CNT_W+1)'(segl_q)) > {1'b0, len_q};

  // Reciprocal of the repeat count, scaled by 2^SH and rounded up.
  always_comb begin
    recip = '0;
    shamt = 0;
    for (int k = 1; k <= MAX_REPS; k++) begin
      if (reps_q == REP_W'(k)) recip = (SH+1)'(((1 << SH) + k - 1) / k);
    end
    for (int k = 0; k < REP_W; k++) begin
      if (reps_q == REP_W'(1 << k)) shamt = k;
    end
  end

  assign prod = {{(SH+1){1'b0}}, acc_rd} * {{ACC_W{1'b0}}, recip};

  always_comb begin
    if ($onehot(reps_q)) avg = SMP_W'(acc_rd >> shamt);
    else                 avg = prod[SH +: SMP_W];
  end

  assign out_valid = active;
  assign out_data  = $signed({1'b0, avg}) - $signed({1'b0, ref_q});
  assign out_first = active && (pos == '0);
  assign out_last  = active && seg_end;
  assign out_idx   = seg;
  assign done      = active && out_ready && seg_end && no_room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      pos <= '0;
      seg <= '0;
    end else if (!active || done) begin
      ptr <= '0;
      pos <= '0;
      seg <= '0;
    end else if (out_ready) begin
      ptr <= ptr + 1'b1;
      if (seg_end) begin
        pos <= '0;
        seg <= seg + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_idx)
      && $stable(out_first) && $stable(out_last));

  // R5
  in_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && !out_first && $stable(out_idx));

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid || (out_first && out_idx == $past(out_idx) + 1'b1));

  // R6
  in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ptr < len_q);
endmodule

// File: rtl/trace_avg.sv
module trace_avg #(
  parameter int SMP_W       = 8,
  parameter int MAX_REPS    = 16,
  parameter int MAX_SEG     = 128,
  parameter int MAX_SAMPLES = 1024
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               smp_valid,
  input  logic [SMP_W-1:0]                   smp_data,
  input  logic                               trig,
  input  logic [$clog2(MAX_REPS+1)-1:0]      cfg_reps,
  input  logic [$clog2(MAX_SEG+1)-1:0]       cfg_seg_len,
  input  logic                               ref_we,
  input  logic [$clog2(MAX_SEG)-1:0]         ref_addr,
  input  logic [SMP_W-1:0]                   ref_data,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [SMP_W:0]                     out_data,
  output logic                               out_first,
  output logic                               out_last,
  output logic [$clog2(MAX_SAMPLES)-1:0]     out_idx,
  output logic                               err_len
);
  localparam int REP_W  = $clog2(MAX_REPS + 1);
  localparam int ACC_W  = SMP_W + $clog2(MAX_REPS);
  localparam int SEGA_W = $clog2(MAX_SEG);
  localparam int SEGL_W = $clog2(MAX_SEG + 1);
  localparam int CNT_W  = $clog2(MAX_SAMPLES + 1);
  localparam int AW     = $clog2(MAX_SAMPLES);
  localparam int IDX_W  = AW;

  logic              acc_we, acc_clear, emit_active, emit_done;
  logic [AW-1:0]     acc_waddr, acc_raddr;
  logic [ACC_W-1:0]  acc_rd;
  logic [CNT_W-1:0]  len_q;
  logic [REP_W-1:0]  reps_q;
  logic [SEGL_W-1:0] segl_q;

  tavg_ctrl #(
    .MAX_SAMPLES(MAX_SAMPLES), .REP_W(REP_W), .SEGL_W(SEGL_W), .CNT_W(CNT_W), .AW(AW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .trig(trig),
    .cfg_reps(cfg_reps), .cfg_seg_len(cfg_seg_len), .emit_done(emit_done),
    .acc_we(acc_we), .acc_clear(acc_clear), .acc_addr(acc_waddr),
    .emit_active(emit_active), .len_q(len_q), .reps_q(reps_q), .segl_q(segl_q),
    .err_len(err_len)
  );

  tavg_accmem #(
    .DEPTH(MAX_SAMPLES), .SMP_W(SMP_W), .ACC_W(ACC_W), .AW(AW)
  ) u_mem (
    .clk(clk), .we(acc_we), .clear(acc_clear), .waddr(acc_waddr), .wdata(smp_data),
    .raddr(acc_raddr), .rdata(acc_rd)
  );

  tavg_emit #(
    .SMP_W(SMP_W), .ACC_W(ACC_W), .MAX_REPS(MAX_REPS), .MAX_SEG(MAX_SEG), .REP_W(REP_W),
    .SEGA_W(SEGA_W), .SEGL_W(SEGL_W), .CNT_W(CNT_W), .AW(AW), .IDX_W(IDX_W)
  ) u_emit (
    .clk(clk), .rst_n(rst_n), .active(emit_active), .len_q(len_q), .reps_q(reps_q),
    .segl_q(segl_q), .acc_rd(acc_rd), .acc_raddr(acc_raddr),
    .ref_we(ref_we), .ref_addr(ref_addr), .ref_data(ref_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .out_idx(out_idx), .done(emit_done)
  );
endmodule

// File: tb/sim_trace_avg.sv
`timescale 1ns/1ps
module sim_trace_avg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = '0;
  logic       trig = 1'b1;
  logic [4:0] cfg_reps = 5'd1;
  logic [7:0] cfg_seg_len = 8'd4;
  logic       ref_we = 1'b0;
  logic [6:0] ref_addr = '0;
  logic [7:0] ref_data = '0;
  logic       out_valid, out_ready, out_first, out_last, err_len;
  logic [8:0] out_data;
  logic [9:0] out_idx;

  int n_chk = 0, n_bad = 0, cyc = 0, err_seen = 0;

  // {repeats, segment length, capture length, pattern}
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{5, 8, 16, 0}, '{4, 4, 12, 1}, '{1, 8, 8, 2}, '{3, 4, 10, 2},
    '{16, 4, 8, 1}, '{2, 1, 3, 2}, '{7, 16, 32, 0}, '{5, 128, 256, 2}};

  trace_avg u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data), .trig(trig),
    .cfg_reps(cfg_reps), .cfg_seg_len(cfg_seg_len), .ref_we(ref_we), .ref_addr(ref_addr),
    .ref_data(ref_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .out_idx(out_idx), .err_len(err_len));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && err_len) err_seen <= err_seen + 1;

  always @(posedge clk) if (cyc == 150000) begin
    n_bad++;
    $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  function automatic int samp(int v, int r, int i, int pat);
    case (pat)
      0:       return (i * 5 + r * 40 + v) & 255;
      1:       return 255 - ((r + i) % 2);
      default: return ((i * 73 + r * 151 + v * 29) ^ (i >> 1)) & 255;
    endcase
  endfunction

  function automatic int refv(int v, int j);
    return (j * 37 + v * 59 + 13) & 255;
  endfunction

  function automatic int expv(int v, int reps, int seglen, int i, int pat);
    int s = 0;
    for (int r = 0; r < reps; r++) s += samp(v, r, i, pat);
    return s / reps - refv(v, i % seglen);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_ref(int v, int seglen);
    for (int j = 0; j < seglen; j++) begin
      @(negedge clk);
      ref_we = 1'b1; ref_addr = 7'(j); ref_data = 8'(refv(v, j));
    end
    @(negedge clk);
    ref_we = 1'b0;
  endtask

  // One capture window, with idle sample slots and a sample on the falling cycle
  task automatic capture(int v, int r, int len, int pat);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (i % 3 == 2) begin
        trig = 1'b1; smp_valid = 1'b0; smp_data = 8'h5A;
        @(negedge clk);
      end
      trig = 1'b1; smp_valid = 1'b1; smp_data = 8'(samp(v, r, i, pat));
      @(negedge clk);
    end
    trig = 1'b0; smp_valid = 1'b1; smp_data = 8'hC3;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_set(int v, int reps, int seglen, int len, int pat);
    cfg_reps = 5'(reps); cfg_seg_len = 8'(seglen);
    for (int r = 0; r < reps; r++) capture(v, r, len, pat);
  endtask

  task automatic collect(int v, int reps, int seglen, int len, int pat, bit stall, string req);
    int nb = (len / seglen) * seglen;
    int k = 0;
    int guard = 0;
    while (k < nb && guard < 20000) begin
      out_ready = stall ? ((guard % 4) != 1) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        int ed = expv(v, reps, seglen, k, pat);
        int ad = int'($signed(out_data));
        bit ok = (ad == ed) && (int'(out_idx) == k / seglen) &&
                 (out_first == (k % seglen == 0)) && (out_last == (k % seglen == seglen - 1));
        if (!ok) $display("  beat %0d idx=%0d/%0d first=%0b last=%0b", k, out_idx, k / seglen, out_first, out_last);
        check(ok, req, ad, ed);
        k++;
      end
      @(negedge clk);
      guard++;
    end
    out_ready = 1'b0;
    check(k == nb, {req, " beat count"}, k, nb);
    #1;
    // R6: nothing follows the last whole segment
    check(out_valid == 1'b0, "R6 idle after last segment", int'(out_valid), 0);
  endtask

  initial begin
    int d0, i0, e0;
    out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(err_len == 1'b0, "R1 err_len after reset", int'(err_len), 0);

    // R2: line already high at reset release must not open a window
    cfg_reps = 5'd1; cfg_seg_len = 8'd4;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); smp_valid = 1'b1; smp_data = 8'(i * 9);
    end
    @(negedge clk); smp_valid = 1'b0; trig = 1'b0;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R2 no capture from high-at-reset trigger", int'(out_valid), 0);

    // R3 R4 R5 R6: vector table
    for (int t = 0; t < NV; t++) begin
      load_ref(t, VEC[t][1]);
      run_set(t, VEC[t][0], VEC[t][1], VEC[t][2], VEC[t][3]);
      collect(t, VEC[t][0], VEC[t][1], VEC[t][2], VEC[t][3], bit'(t % 2), "R3/R4/R5 table");
    end

    // R7: third capture shorter than the first
    e0 = err_seen;
    load_ref(21, 4);
    cfg_reps = 5'd3; cfg_seg_len = 8'd4;
    capture(20, 0, 8, 2);
    capture(20, 1, 8, 2);
    capture(20, 2, 6, 2);
    check(err_seen == e0 + 1, "R7 one error pulse", err_seen - e0, 1);
    check(out_valid == 1'b0, "R7 mismatched set not emitted", int'(out_valid), 0);
    run_set(21, 3, 4, 8, 2);
    check(err_seen == e0 + 1, "R7 no error on matching set", err_seen - e0, 1);
    collect(21, 3, 4, 8, 2, 1'b0, "R7 fresh set after discard");

    // R6: set shorter than one segment
    load_ref(40, 8);
    run_set(40, 1, 8, 5, 0);
    check(out_valid == 1'b0, "R6 short set silent", int'(out_valid), 0);
    run_set(40, 1, 8, 8, 0);
    collect(40, 1, 8, 8, 0, 1'b0, "R6 set after short set");

    // R8: stall while the trigger toggles
    load_ref(30, 4);
    run_set(30, 1, 4, 8, 2);
    #1;
    d0 = int'(out_data); i0 = int'(out_idx);
    check(out_valid == 1'b1, "R8 valid before stall", int'(out_valid), 1);
    capture(99, 0, 5, 0);
    #1;
    check(out_valid == 1'b1 && int'(out_data) == d0 && int'(out_idx) == i0,
          "R8 outputs held under stall", int'(out_data), d0);
    collect(30, 1, 4, 8, 2, 1'b0, "R8 trace intact after trigger in emission");

    // R9: configuration change inside a set
    load_ref(50, 4);
    cfg_reps = 5'd2; cfg_seg_len = 8'd4;
    capture(50, 0, 8, 2);
    cfg_reps = 5'd4; cfg_seg_len = 8'd8;
    capture(50, 1, 8, 2);
    collect(50, 2, 4, 8, 2, 1'b0, "R9 latched configuration");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule